// File: doc/BRIEF.md
# 64-bit Integer Execute Unit with Fused Operations

This block is the integer execute stage of a 64-bit core. It takes two 64-bit source operands and a 7-bit operation code, and it returns one 64-bit result and a branch-taken flag. It handles the following:

- shifts, rotates and single-bit operations;
- 32-bit word arithmetic that sign-extends to 64 bits;
- scaled-index address adds;
- several fused forms that an earlier decode stage builds from instruction pairs;
- compare, min/max, byte/bit reversal and packing;
- branch condition evaluation.

The upper three opcode bits pick an operation class, and each class has its own datapath slice. The class outputs are merged in a final select, and one output register follows the select.

Operands enter through a valid/ready handshake, and the result leaves through another one. An operation is accepted on a clock edge where `in_valid` and `in_ready` are both high. Its result appears with `out_valid` high on the following cycle. While `out_valid` is high and `out_ready` is low, the consumer is applying back-pressure. During back-pressure the result and flag stay frozen, and `in_ready` is low so nothing new is taken. A result can be retired and a new operation accepted on the same edge, which gives one operation per cycle at full throughput.

Top module: `alu_rv64`

## Requirements
- R1: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. An accepted operation gives `out_valid` high on the next cycle. While `out_valid && !out_ready`, `out_result` and `out_taken` hold steady. After reset `out_valid` is low.
- R2: Class 000 uses shift amount `src2[5:0]`. The codes are: 0000000 zero-extend `src1[31:0]` then shift left; 0000001 shift left logical; 0000101 shift right logical; 0000111 shift right arithmetic; 0001001 rotate left; 0001011 rotate right; 0000011 set bit; 0000010 clear bit; 0000100 invert bit (`src1 ^ (1<<idx)`); 0000110 extract bit to result bit 0.
- R3: Word codes work on the low 32 bits and sign-extend result bit 31. Word shifts use `src2[4:0]`, and the right shifts read only `src1[31:0]`. The codes are: 0010000 add; 0010010 subtract; 0011000 shift left; 0011001 shift right logical; 0011010 shift right arithmetic; 0011100 rotate left; 0011101 rotate right; 0010001 `src1[0]+src2`; 0010011 sign-extended `src2[11:0]` plus `{src2[31:12],12'b0}`.
- R4: These codes return a part of the 64-bit sum `src1+src2`. 0010100 returns bit 0. 0010101 returns the low 8 bits, zero-extended. 0010110 returns the low 16 bits, zero-extended. 0010111 returns the low 16 bits, sign-extended.
- R5: The plain adds are: 0100001 `src1+src2`; 0100000 zero-extended `src1[31:0]` plus `src2`; 0100010 `src1[0]+src2`; 0100011 sign-extended `src2[11:0]` plus `src2` with its low 12 bits cleared.
- R6: Codes 0100100 to 0100111 add `src1 >> (29+op[1:0])` to `src2`, where the shift is logical. The scaled adds take `src1` shifted left by `op[2:1]+1`, then add `src2`. Odd codes 0101001, 0101011, 0101101 and 0101111 use the full `src1`. Even codes 0101000, 0101010 and 0101100 first zero-extend `src1[31:0]`.
- R7: Class 011 codes: 0110000 subtract; 0110001 unsigned less-than giving 0 or 1; 0110010 signed less-than giving 0 or 1; 0110100 unsigned max; 0110101 unsigned min; 0110110 signed max; 0110111 signed min.
- R8: Class 100 codes: 1000000 and; 1000001 `src1&~src2`; 1000010 or; 1000011 `src1|~src2`; 1000100 xor; 1000101 xnor; 1000110 byte-wise OR-combine, where each nonzero byte becomes 0xFF; 1001000 sign-extend byte; 1001010 sign-extend halfword; 1001001 `{src2[7:0],src1[7:0]}` zero-extended; 1001011 `{src2[15:0],src1[15:0]}` sign-extended from bit 31.
- R9: Class 101 codes: 1010001 reverse byte order; 1010000 reverse the bits inside each byte; 1010010 `{src2[31:0],src1[31:0]}`.
- R10: Class 110 requires `op[3]=0`. Opcode bits 2:1 choose the logic operation: 00 and, 01 or, 10 xor, 11 OR-combine of `src1`. `op[0]=0` keeps only bit 0 of that value. `op[0]=1` returns its low 16 bits, zero-extended.
- R11: Class 111 codes: 1110000 equal; 1110010 not equal; 1111000 signed less-than; 1111010 signed greater-or-equal; 1111100 unsigned less-than; 1111110 unsigned greater-or-equal. A branch gives `out_result` = 0, and `out_taken` is the outcome. Every other class gives `out_taken` = 0.
- R12: Any code not listed above gives `out_result` = 0 and `out_taken` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken this cycle |
| in_op | input | 7 | Operation code |
| in_src1 | input | 64 | First operand |
| in_src2 | input | 64 | Second operand |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 64 | Result value |
| out_taken | output | 1 | Branch condition outcome |

## Verification
Some properties are checked on every cycle:

- the handshake rules, including that the result holds under back-pressure;
- that only branch codes can raise the taken flag;
- that branch results are zero;
- that word results are sign-extended;
- that less-than results are 0 or 1;
- that class-110 results never exceed 16 bits.

The numeric values cannot be shown that way. Rotate wrap-around, the shift amounts that are masked to 5 or 6 bits, the fused-add arithmetic, the reversal orderings and the rejection of unlisted codes are shown only by the bench's vectors with known operands.

// File: rtl/alu_rv64_pkg.sv
package alu_rv64_pkg;
  localparam int XLEN  = 64;
  localparam int OPW   = 7;
  localparam int WLEN  = XLEN / 2;
  localparam int SHW   = $clog2(XLEN);
  localparam int WSHW  = $clog2(WLEN);
  localparam int NBYTE = XLEN / 8;

  localparam logic [2:0] CL_SHIFT = 3'b000;
  localparam logic [2:0] CL_WORD  = 3'b001;
  localparam logic [2:0] CL_ADD   = 3'b010;
  localparam logic [2:0] CL_CMP   = 3'b011;
  localparam logic [2:0] CL_LOGA  = 3'b100;
  localparam logic [2:0] CL_LOGB  = 3'b101;
  localparam logic [2:0] CL_FUSE  = 3'b110;
  localparam logic [2:0] CL_BRAN  = 3'b111;

  localparam logic [OPW-1:0] OP_SLLZW  = 7'b000_0000;
  localparam logic [OPW-1:0] OP_SLL    = 7'b000_0001;
  localparam logic [OPW-1:0] OP_BCLR   = 7'b000_0010;
  localparam logic [OPW-1:0] OP_BSET   = 7'b000_0011;
  localparam logic [OPW-1:0] OP_BINV   = 7'b000_0100;
  localparam logic [OPW-1:0] OP_SRL    = 7'b000_0101;
  localparam logic [OPW-1:0] OP_BEXT   = 7'b000_0110;
  localparam logic [OPW-1:0] OP_SRA    = 7'b000_0111;
  localparam logic [OPW-1:0] OP_ROL    = 7'b000_1001;
  localparam logic [OPW-1:0] OP_ROR    = 7'b000_1011;

  localparam logic [OPW-1:0] OP_ADDW   = 7'b001_0000;
  localparam logic [OPW-1:0] OP_ODDW   = 7'b001_0001;
  localparam logic [OPW-1:0] OP_SUBW   = 7'b001_0010;
  localparam logic [OPW-1:0] OP_LUIW   = 7'b001_0011;
  localparam logic [OPW-1:0] OP_XBIT   = 7'b001_0100;
  localparam logic [OPW-1:0] OP_XBYTE  = 7'b001_0101;
  localparam logic [OPW-1:0] OP_XZH    = 7'b001_0110;
  localparam logic [OPW-1:0] OP_XSH    = 7'b001_0111;
  localparam logic [OPW-1:0] OP_SLLW   = 7'b001_1000;
  localparam logic [OPW-1:0] OP_SRLW   = 7'b001_1001;
  localparam logic [OPW-1:0] OP_SRAW   = 7'b001_1010;
  localparam logic [OPW-1:0] OP_ROLW   = 7'b001_1100;
  localparam logic [OPW-1:0] OP_RORW   = 7'b001_1101;

  localparam logic [OPW-1:0] OP_ADDZW  = 7'b010_0000;
  localparam logic [OPW-1:0] OP_ADD    = 7'b010_0001;
  localparam logic [OPW-1:0] OP_ODD    = 7'b010_0010;
  localparam logic [OPW-1:0] OP_LUI    = 7'b010_0011;
  localparam logic [OPW-1:0] OP_SH4    = 7'b010_1111;

  localparam logic [OPW-1:0] OP_SUB    = 7'b011_0000;
  localparam logic [OPW-1:0] OP_LTU    = 7'b011_0001;
  localparam logic [OPW-1:0] OP_LTS    = 7'b011_0010;
  localparam logic [OPW-1:0] OP_MAXU   = 7'b011_0100;
  localparam logic [OPW-1:0] OP_MINU   = 7'b011_0101;
  localparam logic [OPW-1:0] OP_MAXS   = 7'b011_0110;
  localparam logic [OPW-1:0] OP_MINS   = 7'b011_0111;

  localparam logic [OPW-1:0] OP_AND    = 7'b100_0000;
  localparam logic [OPW-1:0] OP_ANDN   = 7'b100_0001;
  localparam logic [OPW-1:0] OP_OR     = 7'b100_0010;
  localparam logic [OPW-1:0] OP_ORN    = 7'b100_0011;
  localparam logic [OPW-1:0] OP_XOR    = 7'b100_0100;
  localparam logic [OPW-1:0] OP_XNOR   = 7'b100_0101;
  localparam logic [OPW-1:0] OP_ORCB   = 7'b100_0110;
  localparam logic [OPW-1:0] OP_SEXTB  = 7'b100_1000;
  localparam logic [OPW-1:0] OP_PACKB  = 7'b100_1001;
  localparam logic [OPW-1:0] OP_SEXTH  = 7'b100_1010;
  localparam logic [OPW-1:0] OP_PACKHW = 7'b100_1011;

  localparam logic [OPW-1:0] OP_BREVB  = 7'b101_0000;
  localparam logic [OPW-1:0] OP_BSWAP  = 7'b101_0001;
  localparam logic [OPW-1:0] OP_PACKW  = 7'b101_0010;

  function automatic logic [XLEN-1:0] sx32(input logic [WLEN-1:0] v);
    return {{(XLEN-WLEN){v[WLEN-1]}}, v};
  endfunction

  function automatic logic [XLEN-1:0] zx32(input logic [WLEN-1:0] v);
    return {{(XLEN-WLEN){1'b0}}, v};
  endfunction
endpackage

// File: rtl/alu_shift_unit.sv
module alu_shift_unit
  import alu_rv64_pkg::*;
(
  input  logic [OPW-1:0]  op,
  input  logic [XLEN-1:0] a,
  input  logic [SHW-1:0]  shamt,
  output logic [XLEN-1:0] res,
  output logic            hit
);
  logic [XLEN-1:0]   onehot;
  logic [2*XLEN-1:0] dbl, rl_t, rr_t;

  assign onehot = {{(XLEN-1){1'b0}}, 1'b1} << shamt;
  assign dbl    = {a, a};
  assign rl_t   = dbl << shamt;
  assign rr_t   = dbl >> shamt;

  always_comb begin
    hit = 1'b1;
    res = '0;
    case (op)
      OP_SLLZW: res = zx32(a[WLEN-1:0]) << shamt;
      OP_SLL:   res = a << shamt;
      OP_SRL:   res = a >> shamt;
      OP_SRA:   res = $signed(a) >>> shamt;
      OP_ROL:   res = rl_t[2*XLEN-1:XLEN];
      OP_ROR:   res = rr_t[XLEN-1:0];
      OP_BSET:  res = a | onehot;
      OP_BCLR:  res = a & ~onehot;
      OP_BINV:  res = a ^ onehot;
      OP_BEXT:  res = {{(XLEN-1){1'b0}}, a[shamt]};
      default:  hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu_arith_unit.sv
module alu_arith_unit
  import alu_rv64_pkg::*;
(
  input  logic [OPW-1:0]  op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] res,
  output logic            hit
);
  logic [WLEN-1:0]   lo;
  logic [WSHW-1:0]   wsh;
  logic [XLEN-1:0]   sum, diff, odd_sum, luiw_full;
  logic [WLEN-1:0]   sllw_t, srlw_t, sraw_t;
  logic [2*WLEN-1:0] wdbl, wrl, wrr;
  logic [SHW-1:0]    sr_amt;
  logic [2:0]        sh_amt;
  logic [XLEN-1:0]   sh_base;

  assign lo        = a[WLEN-1:0];
  assign wsh       = b[WSHW-1:0];
  assign sum       = a + b;
  assign diff      = a - b;
  assign odd_sum   = {{(XLEN-1){1'b0}}, a[0]} + b;
  assign luiw_full = {{(XLEN-12){b[11]}}, b[11:0]} + {b[XLEN-1:12], 12'b0};
  assign sllw_t    = lo << wsh;
  assign srlw_t    = lo >> wsh;
  assign sraw_t    = $signed(lo) >>> wsh;
  assign wdbl      = {lo, lo};
  assign wrl       = wdbl << wsh;
  assign wrr       = wdbl >> wsh;
  assign sr_amt    = SHW'(29) + {{(SHW-2){1'b0}}, op[1:0]};
  assign sh_amt    = {1'b0, op[2:1]} + 3'd1;
  assign sh_base   = op[0] ? a : zx32(lo);

  always_comb begin
    hit = 1'b1;
    res = '0;
    case (op)
      OP_ADDW:  res = sx32(sum[WLEN-1:0]);
      OP_SUBW:  res = sx32(diff[WLEN-1:0]);
      OP_ODDW:  res = sx32(odd_sum[WLEN-1:0]);
      OP_LUIW:  res = sx32(luiw_full[WLEN-1:0]);
      OP_XBIT:  res = {{(XLEN-1){1'b0}}, sum[0]};
      OP_XBYTE: res = {{(XLEN-8){1'b0}}, sum[7:0]};
      OP_XZH:   res = {{(XLEN-16){1'b0}}, sum[15:0]};
      OP_XSH:   res = {{(XLEN-16){sum[15]}}, sum[15:0]};
      OP_SLLW:  res = sx32(sllw_t);
      OP_SRLW:  res = sx32(srlw_t);
      OP_SRAW:  res = sx32(sraw_t);
      OP_ROLW:  res = sx32(wrl[2*WLEN-1:WLEN]);
      OP_RORW:  res = sx32(wrr[WLEN-1:0]);
      OP_ADDZW: res = zx32(lo) + b;
      OP_ADD:   res = sum;
      OP_ODD:   res = odd_sum;
      OP_LUI:   res = luiw_full;
      7'b010_0100, 7'b010_0101, 7'b010_0110, 7'b010_0111:
                res = (a >> sr_amt) + b;
      7'b010_1000, 7'b010_1001, 7'b010_1010, 7'b010_1011,
      7'b010_1100, 7'b010_1101, OP_SH4:
                res = (sh_base << sh_amt) + b;
      default:  hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu_cmp_unit.sv
module alu_cmp_unit
  import alu_rv64_pkg::*;
(
  input  logic [OPW-1:0]  op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] res,
  output logic            taken,
  output logic            hit
);
  logic lt_s, lt_u, eq, base;

  assign lt_s = $signed(a) < $signed(b);
  assign lt_u = a < b;
  assign eq   = a == b;

  always_comb begin
    case (op[3:2])
      2'b00:   base = eq;
      2'b10:   base = lt_s;
      default: base = lt_u;
    endcase
  end

  always_comb begin
    hit   = 1'b1;
    res   = '0;
    taken = 1'b0;
    if (op[6:4] == CL_BRAN) begin
      if (op[0] == 1'b0 && op[3:2] != 2'b01) taken = base ^ op[1];
      else                                  hit   = 1'b0;
    end else begin
      case (op)
        OP_SUB:  res = a - b;
        OP_LTU:  res = {{(XLEN-1){1'b0}}, lt_u};
        OP_LTS:  res = {{(XLEN-1){1'b0}}, lt_s};
        OP_MAXU: res = lt_u ? b : a;
        OP_MINU: res = lt_u ? a : b;
        OP_MAXS: res = lt_s ? b : a;
        OP_MINS: res = lt_s ? a : b;
        default: hit = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
  import alu_rv64_pkg::*;
(
  input  logic [OPW-1:0]  op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] res,
  output logic            hit
);
  logic [XLEN-1:0] orcb, bswap, brevb, fsel;

  for (genvar g = 0; g < NBYTE; g++) begin : g_byte
    assign orcb[8*g +: 8]              = {8{|a[8*g +: 8]}};
    assign bswap[8*(NBYTE-1-g) +: 8]   = a[8*g +: 8];
    for (genvar k = 0; k < 8; k++) begin : g_bit
      assign brevb[8*g + k] = a[8*g + 7 - k];
    end
  end

  always_comb begin
    case (op[2:1])
      2'b00:   fsel = a & b;
      2'b01:   fsel = a | b;
      2'b10:   fsel = a ^ b;
      default: fsel = orcb;
    endcase
  end

  always_comb begin
    hit = 1'b1;
    res = '0;
    if (op[6:4] == CL_FUSE) begin
      if (op[3])      hit = 1'b0;
      else if (op[0]) res = {{(XLEN-16){1'b0}}, fsel[15:0]};
      else            res = {{(XLEN-1){1'b0}}, fsel[0]};
    end else begin
      case (op)
        OP_AND:    res = a & b;
        OP_ANDN:   res = a & ~b;
        OP_OR:     res = a | b;
        OP_ORN:    res = a | ~b;
        OP_XOR:    res = a ^ b;
        OP_XNOR:   res = ~(a ^ b);
        OP_ORCB:   res = orcb;
        OP_SEXTB:  res = {{(XLEN-8){a[7]}}, a[7:0]};
        OP_SEXTH:  res = {{(XLEN-16){a[15]}}, a[15:0]};
        OP_PACKB:  res = {{(XLEN-16){1'b0}}, b[7:0], a[7:0]};
        OP_PACKHW: res = sx32({b[15:0], a[15:0]});
        OP_BSWAP:  res = bswap;
        OP_BREVB:  res = brevb;
        OP_PACKW:  res = {b[WLEN-1:0], a[WLEN-1:0]};
        default:   hit = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/alu_rv64.sv
module alu_rv64
  import alu_rv64_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [OPW-1:0]  in_op,
  input  logic [XLEN-1:0] in_src1,
  input  logic [XLEN-1:0] in_src2,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [XLEN-1:0] out_result,
  output logic            out_taken
);
  logic [XLEN-1:0] sh_res, ar_res, cm_res, lg_res, nxt_res;
  logic            sh_hit, ar_hit, cm_hit, lg_hit, cm_taken, nxt_taken;
  logic            accept;

  alu_shift_unit u_shift (.op(in_op), .a(in_src1), .shamt(in_src2[SHW-1:0]),
                          .res(sh_res), .hit(sh_hit));
  alu_arith_unit u_arith (.op(in_op), .a(in_src1), .b(in_src2),
                          .res(ar_res), .hit(ar_hit));
  alu_cmp_unit   u_cmp   (.op(in_op), .a(in_src1), .b(in_src2),
                          .res(cm_res), .taken(cm_taken), .hit(cm_hit));
  alu_logic_unit u_logic (.op(in_op), .a(in_src1), .b(in_src2),
                          .res(lg_res), .hit(lg_hit));

  always_comb begin
    nxt_res   = '0;
    nxt_taken = 1'b0;
    case (in_op[6:4])
      CL_SHIFT:                 if (sh_hit) nxt_res = sh_res;
      CL_WORD, CL_ADD:          if (ar_hit) nxt_res = ar_res;
      CL_CMP, CL_BRAN: if (cm_hit) begin
        nxt_res   = cm_res;
        nxt_taken = cm_taken;
      end
      default:                  if (lg_hit) nxt_res = lg_res;
    endcase
  end

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_taken  <= 1'b0;
    end else if (accept) begin
      out_valid  <= 1'b1;
      out_result <= nxt_res;
      out_taken  <= nxt_taken;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/alu_rv64_chk.sv
module alu_rv64_chk
  import alu_rv64_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [OPW-1:0]  in_op,
  input logic            out_valid,
  input logic            out_ready,
  input logic [XLEN-1:0] out_result,
  input logic            out_taken
);
  logic acc;
  assign acc = in_valid && in_ready;

  // R1
  stall_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
  // R1
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_taken)));
  // R1
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);
  // R1
  drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && out_ready) |=> !out_valid);
  // R11
  nonbranch_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_op[6:4] != CL_BRAN) |=> !out_taken);
  // R11
  branch_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_op[6:4] == CL_BRAN) |=> (out_result == '0));
  // R10
  fuse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_op[6:4] == CL_FUSE) |=> (out_result[XLEN-1:16] == '0));
  // R7
  less_bool_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (in_op == OP_LTU || in_op == OP_LTS)) |=> (out_result[XLEN-1:1] == '0));
  // R3
  word_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_op[6:4] == CL_WORD && in_op != OP_XBIT && in_op != OP_XBYTE && in_op != OP_XZH)
    |=> (out_result[XLEN-1:WLEN] == {(XLEN-WLEN){out_result[WLEN-1]}}));
endmodule

bind alu_rv64 alu_rv64_chk u_alu_rv64_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_op(in_op), .out_valid(out_valid), .out_ready(out_ready),
  .out_result(out_result), .out_taken(out_taken)
);

// File: tb/test_alu_rv64.sv
`timescale 1ns/1ps
module test_alu_rv64;
  typedef struct packed {
    logic [3:0]  req;
    logic [6:0]  op;
    logic [63:0] a;
    logic [63:0] b;
    logic [63:0] r;
    logic        t;
  } vec_t;

  localparam int NV = 61;
  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam vec_t VECS [NV] = '{
    // R2 class 000
    '{4'd2, 7'b000_0001, 64'h1, 64'h43, 64'h8, 1'b0},
    '{4'd2, 7'b000_0101, 64'h8000_0000_0000_0000, 64'h3F, 64'h1, 1'b0},
    '{4'd2, 7'b000_0111, 64'h8000_0000_0000_0000, 64'h3F, ONES, 1'b0},
    '{4'd2, 7'b000_1001, 64'h8000_0000_0000_0001, 64'h1, 64'h3, 1'b0},
    '{4'd2, 7'b000_1011, 64'h1, 64'h1, 64'h8000_0000_0000_0000, 1'b0},
    '{4'd2, 7'b000_1001, 64'h1234, 64'h40, 64'h1234, 1'b0},
    '{4'd2, 7'b000_0000, 64'hFFFF_FFFF_8000_0001, 64'h4, 64'h0000_0008_0000_0010, 1'b0},
    '{4'd2, 7'b000_0011, 64'h0, 64'h7F, 64'h8000_0000_0000_0000, 1'b0},
    '{4'd2, 7'b000_0010, ONES, 64'h0, 64'hFFFF_FFFF_FFFF_FFFE, 1'b0},
    '{4'd2, 7'b000_0100, 64'hF0, 64'h4, 64'hE0, 1'b0},
    '{4'd2, 7'b000_0110, 64'h10, 64'h4, 64'h1, 1'b0},
    // R3 word class
    '{4'd3, 7'b001_0000, 64'h7FFF_FFFF, 64'h1, 64'hFFFF_FFFF_8000_0000, 1'b0},
    '{4'd3, 7'b001_0010, 64'h1234_5678_0000_0000, 64'h1, ONES, 1'b0},
    '{4'd3, 7'b001_1000, 64'h1, 64'h3F, 64'hFFFF_FFFF_8000_0000, 1'b0},
    '{4'd3, 7'b001_1001, 64'hFFFF_FFFF_8000_0000, 64'h4, 64'h0000_0000_0800_0000, 1'b0},
    '{4'd3, 7'b001_1010, 64'h0000_0000_8000_0000, 64'h4, 64'hFFFF_FFFF_F800_0000, 1'b0},
    '{4'd3, 7'b001_1100, 64'h8000_0001, 64'h1, 64'h3, 1'b0},
    '{4'd3, 7'b001_1101, 64'h1, 64'h1, 64'hFFFF_FFFF_8000_0000, 1'b0},
    '{4'd3, 7'b001_0011, 64'h0, 64'h0000_0000_8000_0800, 64'h0000_0000_7FFF_F800, 1'b0},
    // R4 sum extraction
    '{4'd4, 7'b001_0100, 64'h1, 64'h2, 64'h1, 1'b0},
    '{4'd4, 7'b001_0101, 64'hFF, 64'h102, 64'h1, 1'b0},
    '{4'd4, 7'b001_0110, ONES, 64'h0, 64'hFFFF, 1'b0},
    '{4'd4, 7'b001_0111, 64'h8000, 64'h0, 64'hFFFF_FFFF_FFFF_8000, 1'b0},
    // R5 plain adds
    '{4'd5, 7'b010_0000, ONES, 64'h1, 64'h0000_0001_0000_0000, 1'b0},
    '{4'd5, 7'b010_0001, 64'h5, 64'h7, 64'hC, 1'b0},
    '{4'd5, 7'b010_0010, 64'h3, 64'hA, 64'hB, 1'b0},
    '{4'd5, 7'b010_0011, 64'hDEAD, 64'h0000_0000_1234_5FFF, 64'h0000_0000_1234_4FFF, 1'b0},
    // R6 shifted adds
    '{4'd6, 7'b010_0100, 64'h2000_0000, 64'h5, 64'h6, 1'b0},
    '{4'd6, 7'b010_0111, 64'hFFFF_FFFF_0000_0000, 64'h1, 64'h0000_0001_0000_0000, 1'b0},
    '{4'd6, 7'b010_0101, 64'hC000_0000, 64'h0, 64'h3, 1'b0},
    '{4'd6, 7'b010_1001, 64'h3, 64'h1, 64'h7, 1'b0},
    '{4'd6, 7'b010_1010, 64'hFFFF_FFFF_0000_0001, 64'h0, 64'h4, 1'b0},
    '{4'd6, 7'b010_1101, 64'h2, 64'h1, 64'h11, 1'b0},
    '{4'd6, 7'b010_1111, 64'h1, 64'h0, 64'h10, 1'b0},
    // R7 compare class
    '{4'd7, 7'b011_0000, 64'h5, 64'h7, 64'hFFFF_FFFF_FFFF_FFFE, 1'b0},
    '{4'd7, 7'b011_0010, ONES, 64'h0, 64'h1, 1'b0},
    '{4'd7, 7'b011_0001, ONES, 64'h0, 64'h0, 1'b0},
    '{4'd7, 7'b011_0110, ONES, 64'h1, 64'h1, 1'b0},
    '{4'd7, 7'b011_0100, ONES, 64'h1, ONES, 1'b0},
    '{4'd7, 7'b011_0111, ONES, 64'h1, ONES, 1'b0},
    // R8 logic class
    '{4'd8, 7'b100_0000, 64'hF0F0, 64'hFF00, 64'hF000, 1'b0},
    '{4'd8, 7'b100_0001, 64'hF0F0, 64'hFF00, 64'h00F0, 1'b0},
    '{4'd8, 7'b100_0011, 64'hF0F0, 64'hFF00, 64'hFFFF_FFFF_FFFF_F0FF, 1'b0},
    '{4'd8, 7'b100_0101, 64'hF0F0, 64'hFF00, 64'hFFFF_FFFF_FFFF_F00F, 1'b0},
    '{4'd8, 7'b100_0110, 64'h0100_0000_0000_8000, 64'h0, 64'hFF00_0000_0000_FF00, 1'b0},
    '{4'd8, 7'b100_1000, 64'h80, 64'h0, 64'hFFFF_FFFF_FFFF_FF80, 1'b0},
    '{4'd8, 7'b100_1001, 64'h1234, 64'h5678, 64'h7834, 1'b0},
    '{4'd8, 7'b100_1011, 64'h1234, 64'h8000, 64'hFFFF_FFFF_8000_1234, 1'b0},
    // R9 reversal and pack
    '{4'd9, 7'b101_0001, 64'h0102_0304_0506_0708, 64'h0, 64'h0807_0605_0403_0201, 1'b0},
    '{4'd9, 7'b101_0000, 64'h0301, 64'h0, 64'hC080, 1'b0},
    '{4'd9, 7'b101_0010, 64'h1111_1111_2222_2222, 64'h3333_3333_4444_4444, 64'h4444_4444_2222_2222, 1'b0},
    // R10 fused logic with extraction
    '{4'd10, 7'b110_0001, 64'h12345, 64'hFFFFF, 64'h2345, 1'b0},
    '{4'd10, 7'b110_0101, 64'hFFFFF, 64'h10000, 64'hFFFF, 1'b0},
    '{4'd10, 7'b110_0110, 64'h100, 64'h0, 64'h0, 1'b0},
    '{4'd10, 7'b110_0111, 64'h10001, 64'h0, 64'hFF, 1'b0},
    '{4'd10, 7'b110_0000, 64'h3, 64'h1, 64'h1, 1'b0},
    // R11 branch compares
    '{4'd11, 7'b111_0000, 64'h5, 64'h5, 64'h0, 1'b1},
    '{4'd11, 7'b111_0010, 64'h5, 64'h5, 64'h0, 1'b0},
    '{4'd11, 7'b111_1000, ONES, 64'h0, 64'h0, 1'b1},
    '{4'd11, 7'b111_1010, ONES, 64'h0, 64'h0, 1'b0},
    '{4'd11, 7'b111_1100, ONES, 64'h0, 64'h0, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [6:0]  in_op = '0;
  logic [63:0] in_src1 = '0;
  logic [63:0] in_src2 = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_result;
  logic        out_taken;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  alu_rv64 i_alu_rv64 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_src1(in_src1), .in_src2(in_src2),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_taken(out_taken)
  );

  task automatic chk(input int req, input string what, input logic [64:0] got, input logic [64:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic run_op(input int req, input logic [6:0] op, input logic [63:0] a,
                        input logic [63:0] b, input logic [63:0] r, input logic t);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_src1 = a; in_src2 = b;
    @(negedge clk);
    in_valid = 1'b0;
    chk(req, $sformatf("op %b", op), {out_valid, out_result},
        {1'b1, r});
    chk(req, $sformatf("op %b taken", op), {64'h0, out_taken}, {64'h0, t});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(1, "out_valid in reset", {64'h0, out_valid}, 65'h0);
    chk(1, "in_ready in reset", {64'h0, in_ready}, 65'h1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(1, "out_valid after reset", {64'h0, out_valid}, 65'h0);

    for (int i = 0; i < NV; i++)
      run_op(VECS[i].req, VECS[i].op, VECS[i].a, VECS[i].b, VECS[i].r, VECS[i].t);

    // R11 unsigned greater-or-equal taken
    run_op(11, 7'b111_1110, ONES, 64'h0, 64'h0, 1'b1);
    // R12 unlisted codes in several classes
    run_op(12, 7'b000_1000, ONES, 64'h3, 64'h0, 1'b0);
    run_op(12, 7'b111_0001, 64'h5, 64'h5, 64'h0, 1'b0);
    run_op(12, 7'b110_1000, 64'hFF, 64'hFF, 64'h0, 1'b0);
    run_op(12, 7'b011_0011, 64'h9, 64'h2, 64'h0, 1'b0);
    run_op(12, 7'b111_0100, 64'h5, 64'h5, 64'h0, 1'b0);

    // R1 back-pressure: result held, input stalled, then drained
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_op = 7'b010_0001; in_src1 = 64'h1; in_src2 = 64'h1;
    @(negedge clk);
    chk(1, "valid under stall", {64'h0, out_valid}, 65'h1);
    chk(1, "in_ready under stall", {64'h0, in_ready}, 65'h0);
    in_op = 7'b011_0000; in_src1 = 64'h9; in_src2 = 64'h4;
    repeat (2) @(negedge clk);
    chk(1, "held result", {1'b0, out_result}, {1'b0, 64'h2});
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(1, "result after release", {out_valid, out_result}, {1'b1, 64'h5});
    @(negedge clk);
    chk(1, "drained", {64'h0, out_valid}, 65'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R1 watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule